// File: doc/BRIEF.md
# Serial In-System Programming Target Interface

This block is the device-side end of a three-wire programming link. An external programmer drives a serial clock and a data input and reads a data output. The block runs on the faster system clock and oversamples the serial clock to find its edges. It collects instructions of four bytes each and turns every complete, recognised instruction into a single command for the memory controller. That command carries an operation code, an address and a data byte, and the memory controller behind the block carries it out.

Programming mode lasts as long as the active-low request input is held low. When the mode starts, the block is locked. It stays locked until an unlock frame arrives whose opcode byte is 0xAC and whose second byte is 0x53. While the unlock frame is being received, the second byte is echoed on the output during the third byte, so the programmer can confirm that it is in step with the target. A read command is answered later, through a returned data byte. That byte is shifted out in the fourth byte slot of every following frame.

Top module: `isp_target_if`

## Requirements
- R1: A command is issued only after all four bytes of a frame have been received. Bits are taken MSB first on SCK rising edges. Each command is presented on `cmd_valid` for exactly one system clock.
- R2: Byte 1 of a frame is the opcode and selects `cmd_op`. 0x20 gives 1 (read program), 0x40 gives 2 (write program), 0xA0 gives 3 (read EEPROM), 0xC0 gives 4 (write EEPROM) and 0xE0 gives 5 (chip erase).
- R3: After programming mode is entered, no command is issued until a frame with byte 1 = 0xAC and byte 2 = 0x53 has been received. A frame with 0xAC and any other second byte does not unlock. The unlock frame itself issues no command.
- R4: When byte 1 of a frame is 0xAC, the output carries byte 2 of that frame, MSB first, during byte 3. In any other frame the output is 0x00 during byte 3. The output changes only after SCK falling edges.
- R5: For the program-memory commands, `cmd_addr` is {byte 2, byte 3}. For the write commands, `cmd_wdata` is byte 4. For the read commands, `cmd_wdata` is 0x00.
- R6: For the EEPROM commands, `cmd_addr` keeps only the low 12 address bits, and bits 15:12 are zero.
- R7: For a chip erase, `cmd_addr` is 0x0000 and `cmd_wdata` is the fill value 0xFF.
- R8: The byte last returned through `mem_rvalid`/`mem_rdata` is shifted out during byte 4 of every later frame. A frame with an unrecognised opcode issues no command.
- R9: Raising `prog_req_n` clears the byte position and the unlock state. `sdo_en` is high exactly while programming mode is active (after the input synchroniser).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_req_n | input | 1 | Active-low programming-mode request |
| sck | input | 1 | Serial clock from the programmer |
| sdi | input | 1 | Serial data into the target |
| sdo | output | 1 | Serial data out of the target |
| sdo_en | output | 1 | Output driven while in programming mode |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_op | output | 3 | Command code (see R2) |
| cmd_addr | output | 16 | Command address |
| cmd_wdata | output | 8 | Write data or erase fill value |
| mem_rvalid | input | 1 | Read data return strobe |
| mem_rdata | input | 8 | Read data returned by the memory |

## Verification
The bench drives real frames on the serial pins. A locked target receives write and read frames, which show that the gate holds. A wrong-key unlock frame separates echoing from unlocking. A correct unlock frame must echo 0x53. After that, one frame of each command type shows that decoding, EEPROM address masking and the erase fill are separate paths. A read followed by frames with an ignored opcode shows that returned data comes out in byte 4. Leaving the mode in the middle of a frame and then unlocking again shows that both the byte position and the lock are restored.

// File: rtl/isp_tgt_pkg.sv
package isp_tgt_pkg;

    localparam int BYTE_W      = 8;
    localparam int FRAME_BYTES = 4;
    localparam int BYTE_IDX_W  = $clog2(FRAME_BYTES);
    localparam int BIT_IDX_W   = $clog2(BYTE_W);
    localparam int ADDR_W      = 2 * BYTE_W;
    localparam int EE_ADDR_W   = 12;
    localparam int SYNC_STAGES = 2;

    localparam logic [ADDR_W-1:0] EE_MASK = ADDR_W'((1 << EE_ADDR_W) - 1);

    localparam logic [BYTE_W-1:0] OPC_UNLOCK  = 8'hAC;
    localparam logic [BYTE_W-1:0] UNLOCK_KEY  = 8'h53;
    localparam logic [BYTE_W-1:0] OPC_RD_PROG = 8'h20;
    localparam logic [BYTE_W-1:0] OPC_WR_PROG = 8'h40;
    localparam logic [BYTE_W-1:0] OPC_RD_EE   = 8'hA0;
    localparam logic [BYTE_W-1:0] OPC_WR_EE   = 8'hC0;
    localparam logic [BYTE_W-1:0] OPC_ERASE   = 8'hE0;
    localparam logic [BYTE_W-1:0] ERASE_FILL  = 8'hFF;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef byte_t [FRAME_BYTES-1:0] frame_t;

    typedef enum logic [2:0] {
        CMD_NONE    = 3'd0,
        CMD_RD_PROG = 3'd1,
        CMD_WR_PROG = 3'd2,
        CMD_RD_EE   = 3'd3,
        CMD_WR_EE   = 3'd4,
        CMD_ERASE   = 3'd5
    } cmd_e;

    typedef struct packed {
        cmd_e               op;
        logic [ADDR_W-1:0]  addr;
        byte_t              data;
    } isp_cmd_t;

    function automatic cmd_e op_of(input byte_t opc);
        case (opc)
            OPC_RD_PROG: return CMD_RD_PROG;
            OPC_WR_PROG: return CMD_WR_PROG;
            OPC_RD_EE:   return CMD_RD_EE;
            OPC_WR_EE:   return CMD_WR_EE;
            OPC_ERASE:   return CMD_ERASE;
            default:     return CMD_NONE;
        endcase
    endfunction

    function automatic isp_cmd_t build_cmd(input frame_t f);
        isp_cmd_t c;
        c.op   = op_of(f[0]);
        c.addr = {f[1], f[2]};
        c.data = f[3];
        case (c.op)
            CMD_RD_PROG: c.data = '0;
            CMD_RD_EE: begin
                c.addr = c.addr & EE_MASK;
                c.data = '0;
            end
            CMD_WR_EE:   c.addr = c.addr & EE_MASK;
            CMD_ERASE: begin
                c.addr = '0;
                c.data = ERASE_FILL;
            end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/isp_sync.sv
module isp_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q[s] <= RST_VAL;
            end else if (s == 0) begin
                stage_q[s] <= din;
            end else begin
                stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/isp_frame_shift.sv
module isp_frame_shift
    import isp_tgt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   active,
    input  logic   sck_s,
    input  logic   sdi_s,
    input  byte_t  rd_hold,
    output logic   frame_done,
    output frame_t frame,
    output logic   sdo
);

    localparam logic [BYTE_IDX_W-1:0] LAST_BYTE = BYTE_IDX_W'(FRAME_BYTES - 1);
    localparam logic [BYTE_IDX_W-1:0] ECHO_SRC  = BYTE_IDX_W'(1);
    localparam logic [BYTE_IDX_W-1:0] DATA_PREV = BYTE_IDX_W'(FRAME_BYTES - 2);
    localparam logic [BIT_IDX_W-1:0]  LAST_BIT  = BIT_IDX_W'(BYTE_W - 1);

    logic                  sck_d;
    logic                  rise, fall;
    logic [BIT_IDX_W-1:0]  bit_q;
    logic [BYTE_IDX_W-1:0] byte_q;
    byte_t                 rx_q, rx_nxt, tx_q, tx_pend_q, tx_fill;
    logic                  load_pend_q;
    frame_t                frame_q;

    always_ff @(posedge clk) begin
        if (rst) sck_d <= 1'b0;
        else     sck_d <= sck_s;
    end

    assign rise   = active & sck_s & ~sck_d;
    assign fall   = active & ~sck_s & sck_d;
    assign rx_nxt = {rx_q[BYTE_W-2:0], sdi_s};

    // byte staged for the slot that follows the one now completing
    always_comb begin
        tx_fill = '0;
        if (byte_q == ECHO_SRC && frame_q[0] == OPC_UNLOCK) tx_fill = rx_nxt;
        else if (byte_q == DATA_PREV)                          tx_fill = rd_hold;
    end

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            bit_q       <= '0;
            byte_q      <= '0;
            rx_q        <= '0;
            tx_q        <= '0;
            tx_pend_q   <= '0;
            load_pend_q <= 1'b0;
            frame_q     <= '0;
            frame_done  <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (rise) begin
                rx_q  <= rx_nxt;
                bit_q <= bit_q + 1'b1;
                if (bit_q == LAST_BIT) begin
                    frame_q[byte_q] <= rx_nxt;
                    tx_pend_q       <= tx_fill;
                    load_pend_q     <= 1'b1;
                    if (byte_q == LAST_BYTE) begin
                        byte_q     <= '0;
                        frame_done <= 1'b1;
                    end else begin
                        byte_q <= byte_q + 1'b1;
                    end
                end
            end else if (fall) begin
                if (load_pend_q) begin
                    tx_q        <= tx_pend_q;
                    load_pend_q <= 1'b0;
                end else begin
                    tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

    assign frame = frame_q;
    assign sdo   = tx_q[BYTE_W-1];

endmodule

// File: rtl/isp_cmd_decode.sv
module isp_cmd_decode
    import isp_tgt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     active,
    input  logic     frame_done,
    input  frame_t   frame,
    output logic     cmd_valid,
    output isp_cmd_t cmd,
    output logic     unlocked
);

    isp_cmd_t decoded;

    always_comb decoded = build_cmd(frame);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            unlocked  <= 1'b0;
            cmd_valid <= 1'b0;
            cmd       <= '0;
        end else begin
            cmd_valid <= 1'b0;
            if (frame_done) begin
                if (frame[0] == OPC_UNLOCK) begin
                    if (frame[1] == UNLOCK_KEY) unlocked <= 1'b1;
                end else if (unlocked && decoded.op != CMD_NONE) begin
                    cmd_valid <= 1'b1;
                    cmd       <= decoded;
                end
            end
        end
    end

endmodule

// File: rtl/isp_target_if.sv
module isp_target_if
    import isp_tgt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        prog_req_n,
    input  logic        sck,
    input  logic        sdi,
    output logic        sdo,
    output logic        sdo_en,
    output logic        cmd_valid,
    output logic [2:0]  cmd_op,
    output logic [15:0] cmd_addr,
    output logic [7:0]  cmd_wdata,
    input  logic        mem_rvalid,
    input  logic [7:0]  mem_rdata
);

    logic [2:0] pins_s;
    logic       active;
    logic       frame_done;
    logic       unlocked;
    frame_t     frame;
    isp_cmd_t   cmd;
    byte_t      rd_hold;

    isp_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) sync_i (
        .clk  (clk),
        .rst  (rst),
        .din  ({prog_req_n, sdi, sck}),
        .dout (pins_s)
    );

    assign active = ~pins_s[2];

    always_ff @(posedge clk) begin
        if (rst)             rd_hold <= '0;
        else if (mem_rvalid) rd_hold <= mem_rdata;
    end

    isp_frame_shift shift_i (
        .clk        (clk),
        .rst        (rst),
        .active     (active),
        .sck_s      (pins_s[0]),
        .sdi_s      (pins_s[1]),
        .rd_hold    (rd_hold),
        .frame_done (frame_done),
        .frame      (frame),
        .sdo        (sdo)
    );

    isp_cmd_decode dec_i (
        .clk        (clk),
        .rst        (rst),
        .active     (active),
        .frame_done (frame_done),
        .frame      (frame),
        .cmd_valid  (cmd_valid),
        .cmd        (cmd),
        .unlocked   (unlocked)
    );

    assign sdo_en    = active;
    assign cmd_op    = cmd.op;
    assign cmd_addr  = cmd.addr;
    assign cmd_wdata = cmd.data;

endmodule

// File: rtl/isp_target_if_chk.sv
module isp_target_if_chk
    import isp_tgt_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       active,
    input logic       unlocked,
    input logic       frame_done,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic       sdo,
    input logic       sdo_en
);

    AST_ONE_CYCLE_STROBE: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid); // R1

    AST_CMD_AFTER_FRAME: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $past(frame_done)); // R1

    AST_CMD_OP_LEGAL: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_op != CMD_NONE && cmd_op <= CMD_ERASE)); // R2

    AST_LOCKED_OUT: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> unlocked); // R3

    AST_EXIT_RELOCKS: assert property (@(posedge clk) disable iff (rst)
        !active |=> !unlocked && !cmd_valid); // R9

    AST_SDO_KNOWN: assert property (@(posedge clk) disable iff (rst)
        sdo_en |-> !$isunknown(sdo)); // R9

endmodule

bind isp_target_if isp_target_if_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .active     (active),
    .unlocked   (unlocked),
    .frame_done (frame_done),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .sdo        (sdo),
    .sdo_en     (sdo_en)
);

// File: tb/isp_target_if_tb_top.sv
module isp_target_if_tb_top;
    import isp_tgt_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prog_req_n = 1'b1;
    logic        sck = 1'b0;
    logic        sdi = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        sdo, sdo_en, cmd_valid;
    logic [2:0]  cmd_op;
    logic [15:0] cmd_addr;
    logic [7:0]  cmd_wdata;

    int checks = 0;
    int bad    = 0;
    int ncmd   = 0;
    isp_cmd_t expq[$];
    string    reqq[$];

    always #2.5 clk = ~clk;

    isp_target_if dut_i (
        .clk        (clk),
        .rst        (rst),
        .prog_req_n (prog_req_n),
        .sck        (sck),
        .sdi        (sdi),
        .sdo        (sdo),
        .sdo_en     (sdo_en),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_addr   (cmd_addr),
        .cmd_wdata  (cmd_wdata),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic expect_cmd(input cmd_e op, input logic [15:0] a,
                              input byte_t d, input string req);
        isp_cmd_t c;
        c.op = op; c.addr = a; c.data = d;
        expq.push_back(c);
        reqq.push_back(req);
    endtask

    task automatic xfer_byte(input byte_t b, output byte_t got);
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            sdi = b[i];
            repeat (8) @(negedge clk);
            sck = 1'b1;
            repeat (8) @(negedge clk);
            got[i] = sdo;
            sck = 1'b0;
        end
    endtask

    task automatic send_frame(input byte_t b0, input byte_t b1, input byte_t b2,
                              input byte_t b3, output frame_t got);
        byte_t g;
        xfer_byte(b0, g); got[0] = g;
        xfer_byte(b1, g); got[1] = g;
        xfer_byte(b2, g); got[2] = g;
        xfer_byte(b3, g); got[3] = g;
        repeat (8) @(negedge clk);
    endtask

    // monitor / scoreboard, also the memory read model
    initial begin
        isp_cmd_t e;
        string    r;
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (!rst && cmd_valid) begin
                ncmd++;
                if (expq.size() == 0) begin
                    chk(1'b0, "R3", "unexpected command", int'(cmd_op), 0);
                end else begin
                    e = expq.pop_front();
                    r = reqq.pop_front();
                    chk(cmd_op == e.op, r, "cmd_op", int'(cmd_op), int'(e.op));
                    chk(cmd_addr == e.addr, r, "cmd_addr", int'(cmd_addr), int'(e.addr));
                    chk(cmd_wdata == e.data, r, "cmd_wdata", int'(cmd_wdata), int'(e.data));
                end
                if (cmd_op == CMD_RD_PROG || cmd_op == CMD_RD_EE) begin
                    mem_rdata  = cmd_addr[7:0] ^ 8'h5A;
                    mem_rvalid = 1'b1;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        frame_t got;
        byte_t  g;
        int     n0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(sdo_en == 1'b0, "R9", "sdo_en out of mode", int'(sdo_en), 0);
        chk(cmd_valid == 1'b0, "R1", "cmd_valid after reset", int'(cmd_valid), 0);

        prog_req_n = 1'b0;
        repeat (5) @(negedge clk);
        chk(sdo_en == 1'b1, "R9", "sdo_en in mode", int'(sdo_en), 1);

        // R3: locked target ignores commands
        n0 = ncmd;
        send_frame(8'h40, 8'h12, 8'h34, 8'h56, got);
        send_frame(8'h20, 8'h00, 8'h01, 8'h00, got);
        chk(ncmd == n0, "R3", "commands while locked", ncmd - n0, 0);

        // R3/R4: wrong key echoes but does not unlock
        send_frame(OPC_UNLOCK, 8'h12, 8'h00, 8'h00, got);
        chk(got[2] == 8'h12, "R4", "echo of wrong key", int'(got[2]), 'h12);
        send_frame(8'h40, 8'h00, 8'h02, 8'h11, got);
        chk(ncmd == n0, "R3", "wrong key unlocked", ncmd - n0, 0);

        // R3/R4: correct unlock
        send_frame(OPC_UNLOCK, UNLOCK_KEY, 8'h00, 8'h00, got);
        chk(got[2] == 8'h53, "R4", "echo of key", int'(got[2]), 'h53);
        chk(ncmd == n0, "R3", "unlock frame issued cmd", ncmd - n0, 0);

        // R5/R2: write program
        expect_cmd(CMD_WR_PROG, 16'h1234, 8'hA5, "R5");
        send_frame(8'h40, 8'h12, 8'h34, 8'hA5, got);
        chk(got[2] == 8'h00, "R4", "byte3 output non-unlock frame", int'(got[2]), 0);
        chk(expq.size() == 0, "R1", "write prog issued", expq.size(), 0);

        // R6: write EEPROM, address masked
        expect_cmd(CMD_WR_EE, 16'h0F3C, 8'h77, "R6");
        send_frame(8'hC0, 8'hFF, 8'h3C, 8'h77, got);
        // R6: read EEPROM
        expect_cmd(CMD_RD_EE, 16'h0BCD, 8'h00, "R6");
        send_frame(8'hA0, 8'hAB, 8'hCD, 8'h99, got);
        chk(expq.size() == 0, "R6", "EEPROM cmds issued", expq.size(), 0);

        // R7: erase; R8: byte 4 carries last read data (0xCD^0x5A)
        expect_cmd(CMD_ERASE, 16'h0000, 8'hFF, "R7");
        send_frame(8'hE0, 8'h12, 8'h34, 8'h56, got);
        chk(got[3] == 8'h97, "R8", "read data in byte4", int'(got[3]), 'h97);
        chk(expq.size() == 0, "R7", "erase issued", expq.size(), 0);

        // R5: read program, then unknown opcode returns data
        expect_cmd(CMD_RD_PROG, 16'h1234, 8'h00, "R5");
        send_frame(8'h20, 8'h12, 8'h34, 8'hEE, got);
        n0 = ncmd;
        send_frame(8'h00, 8'h00, 8'h00, 8'h00, got);
        chk(got[3] == 8'h6E, "R8", "prog read data in byte4", int'(got[3]), 'h6E);
        chk(ncmd == n0, "R8", "unknown opcode issued cmd", ncmd - n0, 0);

        // R9: leave mid-frame, re-enter relocked and realigned
        xfer_byte(8'h40, g);
        xfer_byte(8'h01, g);
        prog_req_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(sdo_en == 1'b0, "R9", "sdo_en after exit", int'(sdo_en), 0);
        prog_req_n = 1'b0;
        repeat (10) @(negedge clk);
        n0 = ncmd;
        send_frame(8'h40, 8'h00, 8'h10, 8'h99, got);
        chk(ncmd == n0, "R9", "relocked after exit", ncmd - n0, 0);
        send_frame(OPC_UNLOCK, UNLOCK_KEY, 8'h00, 8'h00, got);
        chk(got[2] == 8'h53, "R9", "echo aligned after exit", int'(got[2]), 'h53);
        expect_cmd(CMD_WR_PROG, 16'h0010, 8'h99, "R9");
        send_frame(8'h40, 8'h00, 8'h10, 8'h99, got);
        chk(expq.size() == 0, "R9", "write after reunlock", expq.size(), 0);

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule